// File: doc/BRIEF.md
# Buffered-Register PWM Timer

This block is a single-channel PWM generator that counts up. Three settings control it: a clock divider (prescale), a period limit (reload) and a duty threshold (compare). Each setting has two copies. Software writes one copy, the staging copy. The counter and the comparator read the other copy, the live copy. The staging copy moves into the live copy on an update event. An update event is either a counter overflow or a software-issued update pulse. Because of this, a new frequency or duty cycle starts only at a defined period boundary.

The prescale setting is always staged. The reload setting and the compare setting each have their own input that turns staging off. With staging off, a write takes effect on the next clock edge. The software update pulse loads every staging copy and clears both counters to zero. This lets the timer be set up completely before counting starts, or restarted cleanly at any time. The output is high while the main count is below the live compare value. The number of clocks per period is (prescale+1)·(reload+1).

Top module: `pwm_preload_timer`

## Requirements
- R1: After reset, all counters and all register copies are zero and `pwm_out` is low.
- R2: A write with `wr_sel`=0 stores the prescale value in its staging copy only. The live prescale value changes only on an update event.
- R3: When `period_buf` is 1, a write with `wr_sel`=1 stores the reload value in staging. That value becomes live only on the next update event, so the period in progress finishes with the old settings.
- R4: When `period_buf` is 0, a write with `wr_sel`=1 sets the live reload value at that same clock edge.
- R5: A write with `wr_sel`=2 sets the compare value. When `duty_buf` is 1 it is staged until the next update event. When `duty_buf` is 0 it becomes live at once. A `wr_sel` of 3 writes nothing.
- R6: An overflow is an update event. An overflow occurs on a main-counter step taken when the count equals the live reload value. At an overflow the count wraps to 0 and every staging copy is loaded into its live copy.
- R7: A `sw_update` pulse is an update event. It loads all staging copies and clears the prescale counter and the main counter to 0 at that edge, whatever the value of `cnt_en`.
- R8: `pwm_out` is high exactly when `cnt_en` is 1 and the count is below the live compare value. A compare value of 0 keeps the output low. A compare value above the reload value keeps it high.
- R9: The main counter steps once every (live prescale + 1) clocks. The PWM period is therefore (prescale+1)·(reload+1) clocks.
- R10: While `cnt_en` is 0, both counters hold their values and `pwm_out` is low.
- R11: If the live reload value falls below the current count, the counter keeps stepping up. It wraps to 0 when it reaches its all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable |
| period_buf | input | 1 | 1 = stage reload writes until an update event |
| duty_buf | input | 1 | 1 = stage compare writes until an update event |
| sw_update | input | 1 | Software update event: loads live copies and clears counters |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 prescale, 1 reload, 2 compare, 3 none |
| wr_data | input | DATA_W | Write data, low bits used per register |
| pwm_out | output | 1 | PWM output |

## Verification
A staging or live copy that holds the wrong value can stay hidden until the next update event. After that event it appears in `pwm_out` as a wrong high time or a wrong period. The bench therefore compares the output with a reference model on every cycle, across many update events. A wrong prescale counter or a wrong wrap condition appears within one prescaled step as an edge in the wrong place. A wrap at the reload value instead of at all-ones shows up as a pulse too early, after the reload value has been lowered below the count.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_ARR  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W          = 8,
  parameter bit ALWAYS_BUF = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         buf_en,
  input  logic         uev,
  input  logic [W-1:0] din,
  output logic [W-1:0] live_q
);
  logic [W-1:0] stage_q, stage_d, live_d;
  logic         staged;

  generate
    if (ALWAYS_BUF) begin : g_fixed
      assign staged = 1'b1;
    end else begin : g_select
      assign staged = buf_en;
    end
  endgenerate

  always_comb begin
    stage_d = wr_hit ? din : stage_q;
    live_d  = live_q;
    if (wr_hit && !staged) live_d = din;
    else if (uev)          live_d = stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pc_q, pc_d;
  logic         at_end, pc_ce;

  assign at_end = (pc_q >= limit);
  assign tick   = run && !clear && at_end;
  assign pc_ce  = run || clear;

  always_comb begin
    if (clear)       pc_d = '0;
    else if (at_end) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_ce) pc_q <= pc_d;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt_q,
  output logic         ovf
);
  localparam logic [W-1:0] ALL_ONES = '1;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  assign ovf    = step && ((cnt_q == limit) || (cnt_q == ALL_ONES));
  assign cnt_ce = step || clear;

  always_comb begin
    if (clear || ovf) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_preload_timer.sv
module pwm_preload_timer
  import pwm_timer_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8,
  localparam int DATA_W = (PSC_W > CNT_W) ? PSC_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              period_buf,
  input  logic              duty_buf,
  input  logic              sw_update,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);
  logic [PSC_W-1:0] psc_live;
  logic [CNT_W-1:0] arr_live, duty_live, cnt_q;
  logic             tick, ovf, uev;
  logic             hit_psc, hit_arr, hit_duty;

  assign hit_psc  = wr_en && (reg_sel_e'(wr_sel) == SEL_PSC);
  assign hit_arr  = wr_en && (reg_sel_e'(wr_sel) == SEL_ARR);
  assign hit_duty = wr_en && (reg_sel_e'(wr_sel) == SEL_DUTY);
  assign uev      = ovf || sw_update;

  pwm_shadow_reg #(.W(PSC_W), .ALWAYS_BUF(1'b1)) u_psc (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_psc), .buf_en(1'b1), .uev(uev),
    .din(wr_data[PSC_W-1:0]), .live_q(psc_live));

  pwm_shadow_reg #(.W(CNT_W), .ALWAYS_BUF(1'b0)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_arr), .buf_en(period_buf), .uev(uev),
    .din(wr_data[CNT_W-1:0]), .live_q(arr_live));

  pwm_shadow_reg #(.W(CNT_W), .ALWAYS_BUF(1'b0)) u_duty (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_duty), .buf_en(duty_buf), .uev(uev),
    .din(wr_data[CNT_W-1:0]), .live_q(duty_live));

  pwm_prescaler #(.W(PSC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cnt_en), .clear(sw_update),
    .limit(psc_live), .tick(tick));

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(sw_update), .step(tick),
    .limit(arr_live), .cnt_q(cnt_q), .ovf(ovf));

  assign pwm_out = cnt_en && (cnt_q < duty_live);
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int PSC_W  = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              period_buf,
  input logic              duty_buf,
  input logic              sw_update,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              pwm_out,
  input logic              tick,
  input logic              uev,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PSC_W-1:0]  psc_live,
  input logic [CNT_W-1:0]  arr_live,
  input logic [CNT_W-1:0]  duty_live
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_PSC_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> $stable(psc_live)); // R2
  AST_ARR_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!uev && period_buf) |=> $stable(arr_live)); // R3
  AST_ARR_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && !period_buf) |=> (arr_live == $past(wr_data[CNT_W-1:0]))); // R4
  AST_DUTY_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !duty_buf) |=> (duty_live == $past(wr_data[CNT_W-1:0]))); // R5
  AST_WRAP_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_update && cnt_q == arr_live) |=> (cnt_q == '0)); // R6
  AST_SW_UPDATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |=> (cnt_q == '0)); // R7
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_live == '0) |-> !pwm_out); // R8
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_update && cnt_q != arr_live && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sw_update) |=> $stable(cnt_q)); // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> !pwm_out); // R10
  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_update && cnt_q == TOP) |=> (cnt_q == '0)); // R11
endmodule

bind pwm_preload_timer pwm_timer_checker #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .period_buf(period_buf), .duty_buf(duty_buf),
  .sw_update(sw_update), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out),
  .tick(tick), .uev(uev), .cnt_q(cnt_q), .psc_live(psc_live), .arr_live(arr_live),
  .duty_live(duty_live));

// File: tb/sim_pwm_preload_timer.sv
module sim_pwm_preload_timer;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam logic [W-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, period_buf = 1'b1, duty_buf = 1'b1, sw_update = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd3;
  logic [W-1:0] wr_data = '0;
  logic         pwm_out;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // reference model state
  logic [W-1:0] m_pc, m_cnt, m_psc_s, m_psc_l, m_arr_s, m_arr_l, m_duty_s, m_duty_l;

  always #(CLK_P/2) clk = ~clk;

  pwm_preload_timer #(.PSC_W(W), .CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .period_buf(period_buf), .duty_buf(duty_buf),
    .sw_update(sw_update), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out));

  function automatic logic [W-1:0] staged_next(logic [W-1:0] cur, logic hit, logic [W-1:0] d);
    return hit ? d : cur;
  endfunction

  function automatic logic exp_pwm(logic en, logic [W-1:0] c, logic [W-1:0] duty);
    return en && (c < duty);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = '0; m_cnt = '0; m_psc_s = '0; m_psc_l = '0;
      m_arr_s = '0; m_arr_l = '0; m_duty_s = '0; m_duty_l = '0;
    end else begin
      logic tk, ov, ue;
      logic [W-1:0] ns;
      tk = cnt_en && !sw_update && (m_pc >= m_psc_l);
      ov = tk && (m_cnt == m_arr_l || m_cnt == TOP);
      ue = ov || sw_update;
      if (sw_update) begin m_pc = '0; m_cnt = '0; end
      else if (cnt_en) begin
        m_pc = (m_pc >= m_psc_l) ? '0 : m_pc + 1'b1;
        if (tk) m_cnt = ov ? '0 : m_cnt + 1'b1;
      end
      ns = staged_next(m_psc_s, wr_en && wr_sel == 2'd0, wr_data);
      m_psc_s = ns; if (ue) m_psc_l = ns;
      ns = staged_next(m_arr_s, wr_en && wr_sel == 2'd1, wr_data);
      m_arr_s = ns;
      if (wr_en && wr_sel == 2'd1 && !period_buf) m_arr_l = wr_data; else if (ue) m_arr_l = ns;
      ns = staged_next(m_duty_s, wr_en && wr_sel == 2'd2, wr_data);
      m_duty_s = ns;
      if (wr_en && wr_sel == 2'd2 && !duty_buf) m_duty_l = wr_data; else if (ue) m_duty_l = ns;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      checks++;
      if (pwm_out !== exp_pwm(cnt_en, m_cnt, m_duty_l)) begin
        errors++;
        $display("FAIL %s pwm_out actual=%0b expected=%0b (t=%0t)", tag, pwm_out,
                 exp_pwm(cnt_en, m_cnt, m_duty_l), $time);
      end
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic upd();
    @(negedge clk); sw_update = 1'b1;
    @(negedge clk); sw_update = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(posedge clk); #(CLK_P/4); hi += int'(pwm_out); end
  endtask

  initial begin
    int hi;
    void'($urandom(32'd20240611));
    // R1: reset state
    #(CLK_P*3 + 1);
    chk("R1 pwm during reset", int'(pwm_out), 0);
    @(negedge clk); rst_n = 1'b1; cnt_en = 1'b1;
    count_high(10, hi);
    chk("R1 pwm low after reset with zero settings", hi, 0);

    // R10: disabled counting holds low
    tag = "R10";
    wr(2'd1, 8'd5); wr(2'd2, 8'd3); upd();
    @(negedge clk); cnt_en = 1'b0;
    count_high(12, hi);
    chk("R10 pwm low while disabled", hi, 0);

    // R9 and R7: psc=1 arr=3 duty=2 -> 8-clock period, 4 high
    tag = "R9";
    wr(2'd0, 8'd1); wr(2'd1, 8'd3); wr(2'd2, 8'd2);
    @(negedge clk); sw_update = 1'b1; cnt_en = 1'b1;
    @(posedge clk); #(CLK_P/4); hi = int'(pwm_out); sw_update = 1'b0;
    chk("R7 first cycle after update is high (count cleared)", hi, 1);
    count_high(23, hi); hi += 1;
    chk("R9 high clocks over three periods", hi, 12);

    // R2: prescale staged mid-period
    tag = "R2";
    wr(2'd0, 8'd3); idle(40);
    // R3: reload staged
    tag = "R3";
    period_buf = 1'b1; wr(2'd1, 8'd9); idle(60);
    // R4: reload direct
    tag = "R4";
    period_buf = 1'b0; wr(2'd0, 8'd0); upd(); wr(2'd1, 8'd2); idle(30);
    // R5: duty staged and direct, plus select 3
    tag = "R5";
    duty_buf = 1'b1; wr(2'd2, 8'd1); idle(20);
    duty_buf = 1'b0; wr(2'd2, 8'd2); idle(20);
    wr(2'd3, 8'd0); idle(10);

    // R8: constant levels
    tag = "R8";
    wr(2'd2, 8'd0);
    count_high(30, hi);
    chk("R8 duty zero gives constant low", hi, 0);
    wr(2'd2, 8'd3);
    count_high(30, hi);
    chk("R8 duty above reload gives constant high", hi, 30);

    // R11: reload lowered below the count, wraps at all-ones
    tag = "R11";
    wr(2'd1, 8'd200); wr(2'd2, 8'd5); upd();
    idle(100);
    wr(2'd1, 8'd10);
    count_high(100, hi);
    chk("R11 no early wrap after reload lowered", hi, 0);
    idle(200);

    // R6: random mix, checked cycle by cycle against the model
    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 255));
      wr_en = (r < 48);
      wr_sel = 2'($urandom_range(0, 3));
      case (wr_sel)
        2'd0:    wr_data = W'($urandom_range(0, 3));
        2'd1:    wr_data = W'($urandom_range(0, 15));
        default: wr_data = W'($urandom_range(0, 17));
      endcase
      sw_update = (r >= 250);
      if ($urandom_range(0, 31) == 0) cnt_en = ~cnt_en;
      if ($urandom_range(0, 15) == 0) period_buf = ~period_buf;
      if ($urandom_range(0, 15) == 0) duty_buf = ~duty_buf;
    end
    @(negedge clk); wr_en = 1'b0; sw_update = 1'b0;
    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in %s", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule